// File: doc/BRIEF.md
# JTAG Host Scan Sequencer

This block is the host end of a JTAG link. On one start pulse it runs a complete session against a single target. It resets the target's TAP controller and steps it to the instruction shift state, where it shifts in an instruction. It then goes straight on to the data shift state, shifts a data vector and leaves the TAP parked in Run-Test/Idle. The TCK, TMS, TDI and TRST pins are produced from the system clock. The TDO bits that come back during both shifts are collected into two readback words.

The caller sets the instruction and data values, their lengths and the TCK half-period. All of these are captured when start is accepted. `busy` stays high while a session runs, and `done` pulses once at the end. Shifting is least-significant bit first in both directions. The fixed TMS walks between TAP states are built into the sequencer, so the caller never deals with TAP states.

Top module: `jtag_scan_seq`

## Requirements
- R1: After reset, busy=0, done=0, tck=0, tms=0, tdi=0, trst_n=1, and both readback words are zero.
- R2: A start seen while busy=0 latches every input and sets busy in the next cycle. A start seen while busy=1 is ignored, and the running session finishes with the values latched at its own start.
- R3: Every session begins with one TCK cycle with trst_n=0, followed by RST_CLKS (default 5) TCK cycles with tms=1 and trst_n=1. The TAP therefore sits in Test-Logic-Reset for at least RST_CLKS rising edges.
- R4: TMS, TDI and TRST change only at the system edge where TCK falls. They hold steady for as long as TCK is high.
- R5: After the reset cycles, the TMS values on successive TCK cycles are 0,1,1,0,0, which takes the TAP from Test-Logic-Reset through Run-Test/Idle to Shift-IR.
- R6: In a shift, bit k of the value is driven on TDI in the k-th TCK cycle. TMS is 0 on every bit except the last, which carries TMS=1 and moves the TAP to Exit1.
- R7: After the instruction shift, the TMS values are 1,1,0,0 (Update-IR, Select-DR, Capture-DR, Shift-DR). The data shift follows without passing through Run-Test/Idle.
- R8: After the data shift, the TMS values are 1,0 (Update-DR, Run-Test/Idle). Once busy falls, tck and tms stay at 0.
- R9: The TDO bit is sampled at the system edge where TCK rises, during the k-th shift cycle, and is stored in bit k of ir_out or dr_out. Bits above the shift length read 0.
- R10: An instruction or data length of 0 is treated as 1, and a length above IR_MAX or DR_MAX is treated as that maximum. A half-period value of 0 is treated as 1.
- R11: Each TCK phase lasts H system cycles, where H is the effective half-period. With N = 17 + ir_len + dr_len TCK cycles per session (effective lengths, default RST_CLKS), done is high exactly 2·H·N edges after the start edge, for one cycle, in the same cycle in which busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a session (ignored while busy) |
| half_per | input | DIV_W | TCK phase length in system cycles |
| ir_len | input | $clog2(IR_MAX+1) | Instruction length in bits |
| ir_in | input | IR_MAX | Instruction value, LSB shifted first |
| dr_len | input | $clog2(DR_MAX+1) | Data length in bits |
| dr_in | input | DR_MAX | Data value, LSB shifted first |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle end-of-session pulse |
| ir_out | output | IR_MAX | TDO bits captured during the instruction shift |
| dr_out | output | DR_MAX | TDO bits captured during the data shift |
| trst_n | output | 1 | Target TAP reset, active low |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the target |
| tdo | input | 1 | Test data from the target |

## Verification
If the sequencer is in the wrong step or has a wrong bit index, a wrong TMS value reaches the target. The bench's TAP model then leaves the expected path at that TCK cycle. By the end of the session this shows up as a model state other than Run-Test/Idle, a wrong instruction or data value latched in the model, or wrong readback words. An off-by-one in the divider or in a step count moves the done pulse by a multiple of H cycles, and this is caught on the very session where it happens. Swept lengths and half-periods make sure that the boundaries of every step count are reached.

// File: rtl/jtag_scan_seq.sv
module jtag_scan_seq #(
  parameter int IR_MAX   = 16,
  parameter int DR_MAX   = 32,
  parameter int DIV_W    = 8,
  parameter int RST_CLKS = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [DIV_W-1:0]             half_per,
  input  logic [$clog2(IR_MAX+1)-1:0]  ir_len,
  input  logic [IR_MAX-1:0]            ir_in,
  input  logic [$clog2(DR_MAX+1)-1:0]  dr_len,
  input  logic [DR_MAX-1:0]            dr_in,
  output logic                         busy,
  output logic                         done,
  output logic [IR_MAX-1:0]            ir_out,
  output logic [DR_MAX-1:0]            dr_out,
  output logic                         trst_n,
  output logic                         tck,
  output logic                         tms,
  output logic                         tdi,
  input  logic                         tdo
);
  localparam int IRL_W = $clog2(IR_MAX+1);
  localparam int DRL_W = $clog2(DR_MAX+1);
  localparam int IR_IW = $clog2(IR_MAX);
  localparam int DR_IW = $clog2(DR_MAX);
  localparam int LW    = (IRL_W > DRL_W) ? IRL_W : DRL_W;
  localparam int RW    = $clog2(RST_CLKS+1);
  localparam int MW    = (LW > RW) ? LW : RW;
  localparam int CNT_W = (MW < 3) ? 3 : MW;

  typedef enum logic [2:0] {
    S_IDLE, S_TRST, S_TLR, S_TOIR, S_IR, S_TODR, S_DR, S_TAIL
  } step_t;

  step_t             st;
  logic [CNT_W-1:0]  idx, last;
  logic [DIV_W-1:0]  div_cnt, half_q;
  logic [IRL_W-1:0]  irl_q, irl_eff;
  logic [DRL_W-1:0]  drl_q, drl_eff;
  logic [IR_MAX-1:0] ir_q;
  logic [DR_MAX-1:0] dr_q;
  logic              tck_q, done_q, tick, rise, fall, at_last;

  assign irl_eff = (ir_len == '0) ? IRL_W'(1) :
                   (ir_len > IRL_W'(IR_MAX)) ? IRL_W'(IR_MAX) : ir_len;
  assign drl_eff = (dr_len == '0) ? DRL_W'(1) :
                   (dr_len > DRL_W'(DR_MAX)) ? DRL_W'(DR_MAX) : dr_len;

  assign busy    = (st != S_IDLE);
  assign done    = done_q;
  assign tck     = tck_q;
  assign trst_n  = (st != S_TRST);
  assign tick    = busy && (div_cnt == half_q - DIV_W'(1));
  assign rise    = tick && !tck_q;
  assign fall    = tick && tck_q;
  assign at_last = (idx == last);

  always_comb begin
    case (st)
      S_TLR:   last = CNT_W'(RST_CLKS - 1);
      S_TOIR:  last = CNT_W'(4);
      S_IR:    last = CNT_W'(irl_q) - CNT_W'(1);
      S_TODR:  last = CNT_W'(3);
      S_DR:    last = CNT_W'(drl_q) - CNT_W'(1);
      S_TAIL:  last = CNT_W'(1);
      default: last = '0;
    endcase
  end

  always_comb begin
    case (st)
      S_TRST, S_TLR: tms = 1'b1;
      S_TOIR:        tms = (idx == CNT_W'(1)) || (idx == CNT_W'(2));
      S_IR, S_DR:    tms = at_last;
      S_TODR:        tms = (idx < CNT_W'(2));
      S_TAIL:        tms = (idx == '0);
      default:       tms = 1'b0;
    endcase
  end

  always_comb begin
    case (st)
      S_IR:    tdi = ir_q[idx[IR_IW-1:0]];
      S_DR:    tdi = dr_q[idx[DR_IW-1:0]];
      default: tdi = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      div_cnt <= '0;
      half_q  <= DIV_W'(1);
      irl_q   <= IRL_W'(1);
      drl_q   <= DRL_W'(1);
      ir_q    <= '0;
      dr_q    <= '0;
      ir_out  <= '0;
      dr_out  <= '0;
      tck_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (start) begin
          st      <= S_TRST;
          idx     <= '0;
          div_cnt <= '0;
          tck_q   <= 1'b0;
          half_q  <= (half_per == '0) ? DIV_W'(1) : half_per;
          irl_q   <= irl_eff;
          drl_q   <= drl_eff;
          ir_q    <= ir_in;
          dr_q    <= dr_in;
          ir_out  <= '0;
          dr_out  <= '0;
        end
      end else begin
        div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
        if (rise) begin
          tck_q <= 1'b1;
          if (st == S_IR) ir_out[idx[IR_IW-1:0]] <= tdo;
          if (st == S_DR) dr_out[idx[DR_IW-1:0]] <= tdo;
        end
        if (fall) begin
          tck_q <= 1'b0;
          if (at_last) begin
            idx <= '0;
            if (st == S_TAIL) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              st <= step_t'(st + 3'd1);
            end
          end else begin
            idx <= idx + CNT_W'(1);
          end
        end
      end
    end
  end
endmodule

module jtag_scan_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic tck,
  input logic tms,
  input logic tdi,
  input logic trst_n
);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  p_trst_in_session_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !trst_n |-> busy);

  p_pins_hold_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tck |-> $stable(tms) && $stable(tdi) && $stable(trst_n));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck && !tms && trst_n);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
endmodule

bind jtag_scan_seq jtag_scan_seq_chk u_chk (.*);

// File: tb/jtag_scan_seq_tb.sv
`timescale 1ns/1ps
module jtag_scan_seq_tb;
  localparam int TLR = 0, RTI = 1, SDR = 2, CDR = 3, SHDR = 4, E1DR = 5, PDR = 6, E2DR = 7,
                 UDR = 8, SIR = 9, CIR = 10, SHIR = 11, E1IR = 12, PIR = 13, E2IR = 14, UIR = 15;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [7:0]  half_per = 0;
  logic [4:0]  ir_len = 0;
  logic [15:0] ir_in = 0;
  logic [5:0]  dr_len = 0;
  logic [31:0] dr_in = 0;
  logic        busy, done, trst_n, tck, tms, tdi;
  logic [15:0] ir_out;
  logic [31:0] dr_out;
  logic        tdo = 0;

  int checks = 0, fails = 0, r4_viol = 0;
  bit finished = 0;

  jtag_scan_seq u_dut (.*);

  always #10 clk = ~clk;

  // TAP target model
  int          t_st = TLR, t_irl = 4, t_drl = 10, rst_cnt = 0;
  logic [63:0] t_ir = 0, t_dr = 0, ir_sr = 0, dr_sr = 0;

  function automatic int nxt(int s, logic m);
    case (s)
      TLR:  return m ? TLR  : RTI;
      RTI:  return m ? SDR  : RTI;
      SDR:  return m ? SIR  : CDR;
      CDR:  return m ? E1DR : SHDR;
      SHDR: return m ? E1DR : SHDR;
      E1DR: return m ? UDR  : PDR;
      PDR:  return m ? E2DR : PDR;
      E2DR: return m ? UDR  : SHDR;
      UDR:  return m ? SDR  : RTI;
      SIR:  return m ? TLR  : CIR;
      CIR:  return m ? E1IR : SHIR;
      SHIR: return m ? E1IR : SHIR;
      E1IR: return m ? UIR  : PIR;
      PIR:  return m ? E2IR : PIR;
      E2IR: return m ? UIR  : SHIR;
      default: return m ? SDR : RTI;
    endcase
  endfunction

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) t_st = TLR;
    else begin
      if (t_st == TLR && tms) rst_cnt++;
      case (t_st)
        CIR:  ir_sr = t_ir;
        SHIR: ir_sr = (ir_sr >> 1) | (64'(tdi) << (t_irl - 1));
        UIR:  t_ir  = ir_sr;
        CDR:  dr_sr = t_dr;
        SHDR: dr_sr = (dr_sr >> 1) | (64'(tdi) << (t_drl - 1));
        UDR:  t_dr  = dr_sr;
        default: ;
      endcase
      t_st = nxt(t_st, tms);
    end
  end

  always @(negedge tck)
    tdo = (t_st == SHIR) ? ir_sr[0] : (t_st == SHDR) ? dr_sr[0] : 1'b0;

  // R4 monitor: pins may not move while tck is high
  logic p_tms, p_tdi, p_trst, p_tck;
  initial begin p_tms = 0; p_tdi = 0; p_trst = 1; p_tck = 0; end
  always @(negedge clk) begin
    if (tck && p_tck && (tms !== p_tms || tdi !== p_tdi || trst_n !== p_trst)) r4_viol++;
    p_tms = tms; p_tdi = tdi; p_trst = trst_n; p_tck = tck;
  end

  function automatic logic [63:0] msk(int n);
    return (64'd1 << n) - 64'd1;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic session(int irl_in, int drl_in, int h_in, int e_irl, int e_drl, int e_h,
                         logic [15:0] irv, logic [31:0] drv,
                         logic [63:0] pir, logic [63:0] pdr, bit poke);
    int n = 0;
    int ncyc = 17 + e_irl + e_drl;
    t_ir = pir & msk(e_irl); t_dr = pdr & msk(e_drl);
    t_irl = e_irl; t_drl = e_drl; rst_cnt = 0;
    @(negedge clk);
    half_per = 8'(h_in); ir_len = 5'(irl_in); dr_len = 6'(drl_in);
    ir_in = irv; dr_in = drv; start = 1;
    @(posedge clk); #1 start = 0;
    while (n < 20000) begin
      @(posedge clk); n++;
      #1;
      if (poke && n == 7) begin
        start = 1; ir_in = ~irv; dr_in = ~drv; ir_len = 5'(e_irl ^ 3); half_per = 8'(e_h + 1);
      end else start = 0;
      if (done) break;
    end
    chk(n == 2 * e_h * ncyc, "R11 session length", 64'(n), 64'(2 * e_h * ncyc));
    chk(busy == 0, "R11 busy drops with done", 64'(busy), 0);
    chk(64'(ir_out) == (pir & msk(e_irl)), "R9 R5 ir readback", 64'(ir_out), pir & msk(e_irl));
    chk(64'(dr_out) == (pdr & msk(e_drl)), "R9 R7 dr readback", 64'(dr_out), pdr & msk(e_drl));
    chk(t_ir == (64'(irv) & msk(e_irl)), "R6 R10 target instruction", t_ir, 64'(irv) & msk(e_irl));
    chk(t_dr == (64'(drv) & msk(e_drl)), "R6 R10 target data", t_dr, 64'(drv) & msk(e_drl));
    chk(t_st == RTI, "R8 target parked in idle", 64'(t_st), 64'(RTI));
    chk(rst_cnt == 5, "R3 reset hold clocks", 64'(rst_cnt), 5);
    @(posedge clk); #1;
    chk(done == 0 && tms == 0 && tck == 0, "R8 R11 quiet after done",
        {61'd0, done, tms, tck}, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && tck == 0 && tms == 0 && tdi == 0 && trst_n == 1,
        "R1 pins after reset", {58'd0, busy, done, tck, tms, tdi, trst_n}, 64'h1);
    chk(ir_out == 0 && dr_out == 0, "R1 readback after reset", 64'(ir_out) | 64'(dr_out), 0);

    for (int irl = 1; irl <= 16; irl++) begin
      for (int dj = 0; dj < 4; dj++) begin
        int drl = (dj == 0) ? 1 : (dj == 1) ? 7 : (dj == 2) ? 10 : 32;
        int h = 1 + (irl + dj) % 3;
        logic [15:0] iv = 16'(irl * 16'h9E37 ^ drl * 16'h03C1);
        logic [31:0] dv = 32'h9E3779B9 * 32'(irl + dj + 1);
        logic [63:0] pi = 64'(irl * 1234 + 77);
        logic [63:0] pd = 64'(32'hC3A50F1E ^ (irl << dj));
        session(irl, drl, h, irl, drl, h, iv, dv, pi, pd, 0);
      end
    end

    // R10 clamps: zero lengths and zero half-period
    session(0, 0, 0, 1, 1, 1, 16'h0001, 32'h1, 64'h1, 64'h0, 0);
    // R10 clamps: lengths above the maxima
    session(20, 40, 2, 16, 32, 2, 16'hBEEF, 32'hDEADBEEF, 64'h1234, 64'h0F0F5A5A, 0);
    // R2 start while busy ignored
    session(4, 10, 2, 4, 10, 2, 16'h000A, 32'h2B5, 64'h5, 64'h3C3, 1);

    chk(r4_viol == 0, "R4 pins changed while tck high", 64'(r4_viol), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule